// File: doc/BRIEF.md
# Dual Phase-Accumulator Clock and Strobe Generator

This block makes two timing signals from one system clock. A serial clock comes from the top bit of one 32-bit phase accumulator. A sample strobe, one system clock wide, comes from the overflow carry of a second accumulator. On every running cycle, each accumulator adds its own frequency word to its phase. The clock therefore runs at fsys·F/2^32. The strobe fires once each time the second phase wraps past 2^32. With a 64 MHz system clock, a clock word of 2^30 gives 16 MHz at 50% duty, and a strobe word of 2^26 gives a 1 MHz pulse.

Software sets up the block through a small write port. The settings are two frequency words, two phase preloads and a run length counted in system clocks. These values are copied into the accumulators only when a run starts. Preloading the two phases sets where the strobe falls against the clock edges. Because both accumulators then step by fixed amounts, that relation holds for the whole run. A trigger starts a run with single-cycle resolution. The run ends by itself after the programmed number of cycles. While idle, both outputs stay low.

The controller has two states. In `S_IDLE` the outputs are quiet. The transition *launch* (trigger high and run length not zero) loads the accumulators and enters `S_RUN`. In `S_RUN` the accumulators advance and a down-counter tracks the run. The transition *expire* (counter at one) returns the controller to `S_IDLE`.

Top module: `dual_phase_clkgen`

## Requirements
- R1: After reset and in every cycle while no run is active, `sclk_o` and `cs_o` are both low.
- R2: A write with `cfg_we` high stores `cfg_wdata` in a shadow register chosen by `cfg_addr`. The map is: 0 = clock frequency word, 1 = clock phase preload, 2 = strobe frequency word, 3 = strobe phase preload, 4 = run length. Addresses 5 to 7 are ignored. All shadow registers reset to 0.
- R3: If `trig` is high at a clock edge while idle and the run length is not zero, a run starts. In the first run cycle, `sclk_o` equals bit 31 of the clock phase preload and `cs_o` is low.
- R4: In run cycle k (counting from 0), `sclk_o` is bit 31 of (clock preload + k·clock word) mod 2^32.
- R5: In run cycle k ≥ 1, `cs_o` is high exactly when the addition (strobe preload + (k−1)·strobe word) mod 2^32 + strobe word reaches or exceeds 2^32.
- R6: A run with length N lasts exactly N cycles. The block then returns to idle.
- R7: A trigger while the run length is 0 is ignored, and the outputs stay low.
- R8: Register writes during a run do not change that run. A trigger during a run is ignored. New values apply at the next start.
- R9: A clock word of 2^30 from phase 0 gives a period of 4 cycles: two low, then two high. A strobe word of 2^26 from phase 0 gives a single-cycle pulse every 64 cycles, first at run cycle 64. A strobe preload of 2^32−2^26 moves the first pulse to run cycle 1.
- R10: A clock word that does not divide 2^32 evenly (858993459, about fsys/5) gives the uneven period sequence that R4 predicts, with no correction applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| trig | input | 1 | Start request, sampled at each clock edge |
| sclk_o | output | 1 | Serial clock (accumulator MSB) |
| cs_o | output | 1 | Sample strobe (accumulator carry) |

## Verification
Both outputs come straight from registers. A trigger sampled at edge E0 therefore shows the preloaded state in the cycle after E0. Run cycle k is visible after edge E0+k, and idle levels return after edge E0+N. The driver sets the trigger just after a rising edge and queues one idle item for the cycle before E0. It then queues N run items built from the R4/R5 formulas, followed by trailing idle items. The monitor pops one item at each falling edge, so every expected value lines up with the register state of that exact cycle.

// File: rtl/psg_pkg.sv
package psg_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } run_state_e;

    localparam int ADDR_W        = 3;
    localparam logic [ADDR_W-1:0] REG_CLK_FREQ  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CLK_PHASE = 3'd1;
    localparam logic [ADDR_W-1:0] REG_STB_FREQ  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_STB_PHASE = 3'd3;
    localparam logic [ADDR_W-1:0] REG_RUN_LEN   = 3'd4;
endpackage

// File: rtl/psg_cfg_regs.sv
module psg_cfg_regs #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [psg_pkg::ADDR_W-1:0] addr,
    input  logic [31:0]               wdata,
    output logic [ACC_W-1:0]          clk_freq,
    output logic [ACC_W-1:0]          clk_phase,
    output logic [ACC_W-1:0]          stb_freq,
    output logic [ACC_W-1:0]          stb_phase,
    output logic [CNT_W-1:0]          run_len
);
    import psg_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_freq  <= '0;
            clk_phase <= '0;
            stb_freq  <= '0;
            stb_phase <= '0;
            run_len   <= '0;
        end else if (we) begin
            unique case (addr)
                REG_CLK_FREQ:  clk_freq  <= wdata[ACC_W-1:0];
                REG_CLK_PHASE: clk_phase <= wdata[ACC_W-1:0];
                REG_STB_FREQ:  stb_freq  <= wdata[ACC_W-1:0];
                REG_STB_PHASE: stb_phase <= wdata[ACC_W-1:0];
                REG_RUN_LEN:   run_len   <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/psg_phase_acc.sv
module psg_phase_acc #(
    parameter int ACC_W     = 32,
    parameter bit USE_CARRY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [ACC_W-1:0] freq_in,
    input  logic [ACC_W-1:0] phase_in,
    output logic             tap_o
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] freq_q;
    logic             carry_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, phase_q} + {1'b0, freq_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            freq_q  <= '0;
            carry_q <= 1'b0;
        end else if (load) begin
            phase_q <= phase_in;
            freq_q  <= freq_in;
            carry_q <= 1'b0;
        end else if (adv) begin
            phase_q <= sum[ACC_W-1:0];
            carry_q <= sum[ACC_W];
        end else begin
            carry_q <= 1'b0;
        end
    end

    generate
        if (USE_CARRY) begin : g_carry_tap
            assign tap_o = carry_q;
        end else begin : g_msb_tap
            assign tap_o = phase_q[ACC_W-1];
        end
    endgenerate

    // R5
    single_wide_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && carry_q && !freq_q[ACC_W-1]) |=> !carry_q);

    // R8
    freq_held_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && $past(adv) && !load) |-> $stable(freq_q));
endmodule

// File: rtl/psg_run_ctrl.sv
module psg_run_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] run_len,
    output logic             load,
    output logic             adv,
    output logic             running
);
    import psg_pkg::*;

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             launch, expire;

    assign launch = trig && (run_len != '0);
    assign expire = (cnt_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_d = S_RUN;
            S_RUN:  if (expire) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load    = 1'b0;
        adv     = 1'b0;
        running = 1'b0;
        unique case (state_q)
            S_IDLE: load = launch;
            S_RUN: begin
                adv     = 1'b1;
                running = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load)              cnt_q <= run_len;
        else if (state_q == S_RUN)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // R6
    run_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (cnt_q != '0));

    // R6
    run_ends_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && cnt_q == CNT_W'(1)) |=> (state_q == S_IDLE));

    // R7
    start_needs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(trig) && $past(run_len) != '0));
endmodule

// File: rtl/dual_phase_clkgen.sv
module dual_phase_clkgen #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        trig,
    output logic        sclk_o,
    output logic        cs_o
);
    localparam int N_CH = 2;

    logic [ACC_W-1:0] freq_a  [N_CH];
    logic [ACC_W-1:0] phase_a [N_CH];
    logic [N_CH-1:0]  tap_a;
    logic [CNT_W-1:0] run_len;
    logic             load, adv, running;

    psg_cfg_regs #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .clk_freq  (freq_a[0]),
        .clk_phase (phase_a[0]),
        .stb_freq  (freq_a[1]),
        .stb_phase (phase_a[1]),
        .run_len   (run_len)
    );

    psg_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .run_len (run_len),
        .load    (load),
        .adv     (adv),
        .running (running)
    );

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_acc
            psg_phase_acc #(.ACC_W(ACC_W), .USE_CARRY(ch == 1)) u_acc (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .adv      (adv),
                .freq_in  (freq_a[ch]),
                .phase_in (phase_a[ch]),
                .tap_o    (tap_a[ch])
            );
        end
    endgenerate

    assign sclk_o = running & tap_a[0];
    assign cs_o   = running & tap_a[1];

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!sclk_o && !cs_o));

    // R3
    first_cycle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !cs_o);
endmodule

// File: tb/sim_dual_phase_clkgen.sv
module sim_dual_phase_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        trig = 1'b0;
    logic        sclk_o, cs_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [1:0] expq [$];

    logic [31:0] m_cf = '0, m_cp = '0, m_sf = '0, m_sp = '0, m_len = '0;

    always #4 clk = ~clk;

    dual_phase_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trig(trig), .sclk_o(sclk_o), .cs_o(cs_o)
    );

    always @(negedge clk) begin
        if (expq.size() > 0) begin
            logic [1:0] e;
            e = expq.pop_front();
            checks++;
            if ({sclk_o, cs_o} !== e) begin
                errors++;
                $display("FAIL %s: sclk/cs actual %b%b expected %b%b", cur_req,
                         sclk_o, cs_o, e[1], e[0]);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (a)
            3'd0: m_cf = d;
            3'd1: m_cp = d;
            3'd2: m_sf = d;
            3'd3: m_sp = d;
            3'd4: m_len = d;
            default: ;
        endcase
    endtask

    task automatic push_run();
        logic [31:0] cph, sph;
        logic [32:0] s;
        logic        cy;
        cph = m_cp; sph = m_sp; cy = 1'b0;
        for (int k = 0; k < int'(m_len); k++) begin
            expq.push_back({cph[31], cy});
            cph = cph + m_cf;
            s   = {1'b0, sph} + {1'b0, m_sf};
            sph = s[31:0];
            cy  = s[32];
        end
    endtask

    // hold: trig cycles; mid: do a disruptive write after start
    task automatic run(input string req, input int hold, input bit mid);
        logic [31:0] sv_cf, sv_len;
        @(posedge clk); #1;
        cur_req = req;
        expq.push_back(2'b00);
        if (m_len != 0) push_run();
        for (int i = 0; i < 3; i++) expq.push_back(2'b00);
        trig = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
        end
        trig = 1'b0;
        if (mid) begin
            sv_cf = m_cf; sv_len = m_len;
            wr(3'd0, 32'h2000_0000);
            wr(3'd4, 32'd3);
            wr(3'd0, sv_cf);
            wr(3'd4, sv_len);
        end
        while (expq.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (sclk_o !== 1'b0 || cs_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual %b%b expected 00", sclk_o, cs_o);
        end

        // R7: run length still zero after reset, trigger ignored
        wr(3'd0, 32'h4000_0000);
        wr(3'd2, 32'h0400_0000);
        run("R7", 1, 1'b0);

        // R9 R4 R5 R6: binary ratios from phase zero
        wr(3'd4, 32'd140);
        run("R9", 1, 1'b0);

        // R3: preloaded phases, clock starts high, strobe at cycle 1
        wr(3'd1, 32'h8000_0000);
        wr(3'd3, 32'hFC00_0000);
        wr(3'd4, 32'd70);
        run("R3", 1, 1'b0);

        // R2: writes to unused addresses leave the map unchanged
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0000_0001);
        run("R2", 1, 1'b0);

        // R8: trigger held and registers rewritten mid-run
        wr(3'd1, 32'h1234_5678);
        wr(3'd4, 32'd40);
        run("R8", 6, 1'b1);

        // R10: non-power-of-two word, uneven periods
        wr(3'd0, 32'd858993459);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h5555_5555);
        wr(3'd4, 32'd60);
        run("R10", 1, 1'b0);

        // R6: single-cycle run
        wr(3'd4, 32'd1);
        run("R6", 1, 1'b0);

        // R5: strobe word with bit 31 set, carries on consecutive cycles allowed
        wr(3'd2, 32'hC000_0000);
        wr(3'd4, 32'd20);
        run("R5", 1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule